// File: doc/BRIEF.md
# XOR Perceptron On-Chip Trainer

This block trains a tiny two-layer perceptron (two inputs, two hidden neurons, one output neuron, each neuron with a bias) to reproduce the two-input exclusive-OR function. It does all of the training itself. A controller steps one shared multiply-accumulate unit through four stages: weight seeding, the forward pass, the error terms and the weight update. The nine parameters live in a small register file. One training epoch shows the network the four input pairs in a fixed order.

Software loads a seed and an epoch limit, then pulses `start`. Training ends after an epoch with no misclassification, or when the limit is reached. `done` then rises, and `converged` tells the two endings apart. At any time the query pins evaluate the current network combinationally. Once training has finished, the query pins give the trained answer.

Top module: `mlp_xor_trainer`

## Requirements
- R1: After reset, `done` and `converged` are 0 and every weight and bias is 0. As a result, `q_y` is 1 for all four query inputs.
- R2: A `start` pulse taken while idle clears `done` and `converged`. It then loads the nine parameters, in index order, from a 16-bit Galois LFSR. The LFSR shifts right and XORs 0xB400 when the bit shifted out is 1. The seed value 0 is replaced by 1. Each parameter is bits 12:0 of the current LFSR state, sign-extended, so it lies in -1..+1 in Q4.12.
- R3: The neuron output is 1 when the saturated net value (bias plus weighted inputs) is non-negative, and 0 otherwise. `q_y` is computed combinationally from the current parameters, the hidden layer first.
- R4: Parameter index layout: 0..2 are bias, x0 weight and x1 weight of hidden neuron 0. 3..5 are the same for hidden neuron 1. 6..8 are the output bias and the weights from hidden 0 and hidden 1. The patterns run in the order index p = 0..3, with x0 = p[1] and x1 = p[0]. Seeding takes 9 cycles. Each pattern takes 21 cycles (9 forward, 3 delta, 9 update). Each epoch adds one closing cycle. `done` is seen 9 + 85·k clock edges after the edge that takes `start`, where k is the number of epochs run.
- R5: Arithmetic is 16-bit signed Q4.12. A product is taken at full width, shifted arithmetically right by 12, then saturated. Every sum saturates. A weight change is the saturated product shifted arithmetically right by one more bit (learning rate 0.5).
- R6: The output delta is target minus output: +1, 0 or -1 in Q4.12. Each hidden delta is the output delta times that hidden neuron's pre-update output weight. Each weight changes by delta times its source activation, and a bias uses a source of 1.
- R7: After an epoch with zero misclassified patterns, `done` and `converged` both rise.
- R8: Once the epoch count reaches the limit latched at start, `done` rises and `converged` stays 0. A limit of 0 acts as a limit of 1.
- R9: A `start` pulse during training is ignored, so the finishing time and the result are unchanged.
- R10: After convergence, `q_y` equals x0 XOR x1 for all four inputs.
- R11: `done` and `converged` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training when idle |
| seed | input | 16 | Seed for the parameter initialiser |
| epoch_limit | input | EPW | Maximum number of epochs |
| q_x0 | input | 1 | Query input x0 |
| q_x1 | input | 1 | Query input x1 |
| q_y | output | 1 | Network output for the query inputs |
| done | output | 1 | Training finished |
| converged | output | 1 | Training finished with zero errors |

## Verification
Two events can fall in the same cycle: a fresh `start` pulse, and the controller being busy in the middle of an epoch's updates. The bench provokes this by pulsing `start` deep inside a run. It judges the outcome by comparing the cycle at which `done` rises, the `converged` flag and every query answer against a bit-exact software model of the same training run that saw no extra pulse. A second overlap is a query made while a weight write is landing. That result is judged only after `done`, against the model's final parameters.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int DW    = 16;
  localparam int FRAC  = 12;
  localparam int NWGT  = 9;
  localparam int STEPW = 4;
  localparam int WW    = 2 * DW + 1;

  typedef logic signed [DW-1:0] fx_t;
  typedef logic signed [WW-1:0] wide_t;

  localparam fx_t FX_ONE = fx_t'(1 << FRAC);

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_FWD, ST_DELTA, ST_UPD, ST_EPOCH
  } st_t;

  // clamp a wide value to the signed DW-bit range
  function automatic fx_t fx_sat(input wide_t v);
    wide_t hi;
    wide_t lo;
    hi = wide_t'((64'sd1 <<< (DW - 1)) - 64'sd1);
    lo = -hi - wide_t'(1);
    if (v > hi) return fx_t'(hi);
    if (v < lo) return fx_t'(lo);
    return fx_t'(v);
  endfunction

  function automatic fx_t fx_mul(input fx_t a, input fx_t b);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    return fx_sat(p >>> FRAC);
  endfunction

  // acc + a*b, with the product optionally halved (learning rate)
  function automatic fx_t fx_mac(input fx_t acc, input fx_t a, input fx_t b,
                                 input logic half);
    fx_t t;
    t = fx_mul(a, b);
    if (half) t = t >>> 1;
    return fx_sat(wide_t'(acc) + wide_t'(t));
  endfunction

  function automatic logic fx_act(input fx_t v);
    return ~v[DW-1];
  endfunction

  function automatic fx_t fx_bit(input logic b);
    return b ? FX_ONE : '0;
  endfunction

  function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] r,
                                              input logic [DW-1:0] taps);
    return r[0] ? ((r >> 1) ^ taps) : (r >> 1);
  endfunction

  function automatic fx_t lfsr_to_weight(input logic [DW-1:0] r);
    return fx_t'({{(DW - FRAC - 1){r[FRAC]}}, r[FRAC:0]});
  endfunction
endpackage

// File: rtl/mlp_mac.sv
module mlp_mac
  import mlp_pkg::*;
(
  input  fx_t  acc_i,
  input  fx_t  a_i,
  input  fx_t  b_i,
  input  logic half_i,
  output fx_t  y_o
);
  assign y_o = fx_mac(acc_i, a_i, b_i, half_i);
endmodule

// File: rtl/mlp_weight_file.sv
module mlp_weight_file
  import mlp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [STEPW-1:0]       widx,
  input  fx_t                    wdata,
  output fx_t [NWGT-1:0]         weights
);
  for (genvar i = 0; i < NWGT; i++) begin : g_cell
    fx_t cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cell_q <= '0;
      else if (we && widx == STEPW'(i))        cell_q <= wdata;
    end
    assign weights[i] = cell_q;
  end

  AST_WIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx < STEPW'(NWGT)));  // R4
endmodule

// File: rtl/mlp_query.sv
module mlp_query
  import mlp_pkg::*;
(
  input  fx_t [NWGT-1:0] weights,
  input  logic           x0,
  input  logic           x1,
  output logic           y
);
  fx_t  net_h0, net_h1, net_o;
  logic h0, h1;

  always_comb begin
    net_h0 = fx_mac(fx_mac(fx_mac('0, weights[0], FX_ONE, 1'b0),
                           weights[1], fx_bit(x0), 1'b0),
                    weights[2], fx_bit(x1), 1'b0);
    net_h1 = fx_mac(fx_mac(fx_mac('0, weights[3], FX_ONE, 1'b0),
                           weights[4], fx_bit(x0), 1'b0),
                    weights[5], fx_bit(x1), 1'b0);
    h0 = fx_act(net_h0);
    h1 = fx_act(net_h1);
    net_o = fx_mac(fx_mac(fx_mac('0, weights[6], FX_ONE, 1'b0),
                          weights[7], fx_bit(h0), 1'b0),
                   weights[8], fx_bit(h1), 1'b0);
    y = fx_act(net_o);
  end
endmodule

// File: rtl/mlp_xor_trainer.sv
module mlp_xor_trainer
  import mlp_pkg::*;
#(
  parameter int              EPW       = 16,
  parameter logic [DW-1:0]   LFSR_TAPS = 16'hB400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   seed,
  input  logic [EPW-1:0]  epoch_limit,
  input  logic            q_x0,
  input  logic            q_x1,
  output logic            q_y,
  output logic            done,
  output logic            converged
);
  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(NWGT - 1);

  st_t              state;
  logic [STEPW-1:0] step;
  logic [1:0]       pat;
  logic [EPW-1:0]   epoch_q, lim_q;
  logic [2:0]       errs;
  logic [DW-1:0]    lfsr;
  fx_t              acc, dlt_o, dlt_h0, dlt_h1;
  logic [1:0]       hid;
  logic             y_q, done_q, conv_q;

  fx_t [NWGT-1:0]   weights;
  logic             wr_fire;
  logic [STEPW-1:0] wr_idx;
  fx_t              wr_data;

  fx_t  mac_acc, mac_a, mac_b, mac_out, src;
  logic mac_half;
  logic [1:0] nidx, term;
  logic x0, x1, tgt, busy, pat_wrong, last_epoch;
  fx_t  cur_w;

  assign x0        = pat[1];
  assign x1        = pat[0];
  assign tgt       = x0 ^ x1;
  assign busy      = (state != ST_IDLE);
  assign pat_wrong = (y_q != tgt);
  assign last_epoch = ({1'b0, epoch_q} + (EPW+1)'(1)) >= {1'b0, lim_q};
  assign cur_w     = weights[step];

  always_comb begin
    if (step < STEPW'(3))      begin nidx = 2'd0; term = 2'(step); end
    else if (step < STEPW'(6)) begin nidx = 2'd1; term = 2'(step - STEPW'(3)); end
    else                       begin nidx = 2'd2; term = 2'(step - STEPW'(6)); end
  end

  // source activation for the parameter selected by step
  always_comb begin
    if (term == 2'd0)      src = FX_ONE;
    else if (term == 2'd1) src = (nidx == 2'd2) ? fx_bit(hid[0]) : fx_bit(x0);
    else                   src = (nidx == 2'd2) ? fx_bit(hid[1]) : fx_bit(x1);
  end

  always_comb begin
    mac_acc  = '0;
    mac_a    = cur_w;
    mac_b    = src;
    mac_half = 1'b0;
    case (state)
      ST_FWD: mac_acc = (term == 2'd0) ? fx_t'(0) : acc;
      ST_DELTA: begin
        mac_a = dlt_o;
        mac_b = (step == STEPW'(2)) ? weights[8] : weights[7];
      end
      ST_UPD: begin
        mac_acc  = cur_w;
        mac_a    = (nidx == 2'd0) ? dlt_h0 : (nidx == 2'd1) ? dlt_h1 : dlt_o;
        mac_half = 1'b1;
      end
      default: ;
    endcase
  end

  mlp_mac u_mac (
    .acc_i (mac_acc), .a_i (mac_a), .b_i (mac_b), .half_i (mac_half), .y_o (mac_out)
  );

  assign wr_fire = (state == ST_INIT) || (state == ST_UPD);
  assign wr_idx  = step;
  assign wr_data = (state == ST_INIT) ? lfsr_to_weight(lfsr) : mac_out;

  mlp_weight_file u_wf (
    .clk (clk), .rst_n (rst_n), .we (wr_fire), .widx (wr_idx),
    .wdata (wr_data), .weights (weights)
  );

  mlp_query u_q (.weights (weights), .x0 (q_x0), .x1 (q_x1), .y (q_y));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; step <= '0; pat <= '0; epoch_q <= '0; lim_q <= '0;
      errs <= '0; lfsr <= '0; acc <= '0; dlt_o <= '0; dlt_h0 <= '0;
      dlt_h1 <= '0; hid <= '0; y_q <= 1'b0; done_q <= 1'b0; conv_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_INIT;
          step    <= '0;
          pat     <= '0;
          epoch_q <= '0;
          errs    <= '0;
          lim_q   <= epoch_limit;
          lfsr    <= (seed == '0) ? DW'(1) : seed;
          done_q  <= 1'b0;
          conv_q  <= 1'b0;
        end
        ST_INIT: begin
          lfsr <= lfsr_step(lfsr, LFSR_TAPS);
          if (step == LAST_STEP) begin step <= '0; state <= ST_FWD; end
          else step <= step + STEPW'(1);
        end
        ST_FWD: begin
          acc <= mac_out;
          if (term == 2'd2) begin
            if (nidx == 2'd0)      hid[0] <= fx_act(mac_out);
            else if (nidx == 2'd1) hid[1] <= fx_act(mac_out);
            else                   y_q    <= fx_act(mac_out);
          end
          if (step == LAST_STEP) begin step <= '0; state <= ST_DELTA; end
          else step <= step + STEPW'(1);
        end
        ST_DELTA: begin
          if (step == STEPW'(0)) begin
            dlt_o <= !pat_wrong ? fx_t'(0) : (tgt ? FX_ONE : -FX_ONE);
            errs  <= errs + {2'b0, pat_wrong};
            step  <= STEPW'(1);
          end else if (step == STEPW'(1)) begin
            dlt_h0 <= mac_out;
            step   <= STEPW'(2);
          end else begin
            dlt_h1 <= mac_out;
            step   <= '0;
            state  <= ST_UPD;
          end
        end
        ST_UPD: begin
          if (step == LAST_STEP) begin
            step <= '0;
            if (pat == 2'd3) state <= ST_EPOCH;
            else begin pat <= pat + 2'd1; state <= ST_FWD; end
          end else step <= step + STEPW'(1);
        end
        ST_EPOCH: begin
          epoch_q <= epoch_q + EPW'(1);
          pat     <= '0;
          errs    <= '0;
          if (errs == 3'd0) begin
            done_q <= 1'b1; conv_q <= 1'b1; state <= ST_IDLE;
          end else if (last_epoch) begin
            done_q <= 1'b1; state <= ST_IDLE;
          end else state <= ST_FWD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign converged = conv_q;

  AST_CONV_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |-> done_q);  // R7
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);  // R11
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> (done_q && $stable(conv_q)));  // R11
  AST_INIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT) |-> (wr_data >= -FX_ONE && wr_data < FX_ONE));  // R2
  AST_DELTA_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (dlt_o == '0 || dlt_o == FX_ONE || dlt_o == -FX_ONE));  // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != ST_EPOCH) |=> busy);  // R9
  AST_FINISH_AT_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state) == ST_EPOCH));  // R4
endmodule

// File: tb/mlp_xor_trainer_test.sv
module mlp_xor_trainer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] epoch_limit = '0;
  logic        q_x0 = 1'b0, q_x1 = 1'b0;
  logic        q_y, done, converged;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  mlp_xor_trainer uut (
    .clk (clk), .rst_n (rst_n), .start (start), .seed (seed),
    .epoch_limit (epoch_limit), .q_x0 (q_x0), .q_x1 (q_x1), .q_y (q_y),
    .done (done), .converged (converged)
  );

  // {seed, epoch limit}
  localparam logic [31:0] VECS [8] = '{
    32'h0001_0064, 32'hACE1_0064, 32'h1234_0064, 32'hBEEF_003C,
    32'h5A5A_0064, 32'h0F0F_0005, 32'h7777_0002, 32'hC3C3_0064
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---- independent reference model ----
  function automatic int clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int qm(input int a, input int b, input int acc, input bit half);
    longint p;
    int t;
    p = longint'(a) * longint'(b);
    t = clamp16(p >>> 12);
    if (half) t = t >>> 1;
    return clamp16(longint'(acc) + longint'(t));
  endfunction

  function automatic int neuron(input int bw, input int wa, input int wb,
                                input int sa, input int sb);
    int n;
    n = qm(bw, 4096, 0, 0);
    n = qm(wa, sa, n, 0);
    n = qm(wb, sb, n, 0);
    return (n >= 0) ? 1 : 0;
  endfunction

  function automatic int infer(input int w[9], input int a, input int b);
    int h0, h1;
    h0 = neuron(w[0], w[1], w[2], a * 4096, b * 4096);
    h1 = neuron(w[3], w[4], w[5], a * 4096, b * 4096);
    return neuron(w[6], w[7], w[8], h0 * 4096, h1 * 4096);
  endfunction

  task automatic model(input int sd, input int lim, output int ep,
                       output bit cv, output int w[9]);
    int r, v, errs, a, b, h0, h1, y, t, d_o, dh0, dh1, d, s;
    r = (sd == 0) ? 1 : sd;
    for (int k = 0; k < 9; k++) begin
      v = r & 'h1FFF;
      if (v >= 4096) v -= 8192;
      w[k] = v;
      r = (r & 1) ? ((r >> 1) ^ 'hB400) : (r >> 1);
    end
    ep = 0;
    cv = 0;
    forever begin
      errs = 0;
      for (int p = 0; p < 4; p++) begin
        a = (p >> 1) & 1;
        b = p & 1;
        h0 = neuron(w[0], w[1], w[2], a * 4096, b * 4096);
        h1 = neuron(w[3], w[4], w[5], a * 4096, b * 4096);
        y  = neuron(w[6], w[7], w[8], h0 * 4096, h1 * 4096);
        t  = a ^ b;
        d_o = (t - y) * 4096;
        if (y != t) errs++;
        dh0 = qm(d_o, w[7], 0, 0);
        dh1 = qm(d_o, w[8], 0, 0);
        for (int i = 0; i < 9; i++) begin
          d = (i < 3) ? dh0 : (i < 6) ? dh1 : d_o;
          case (i % 3)
            0: s = 4096;
            1: s = (i < 6) ? a * 4096 : h0 * 4096;
            default: s = (i < 6) ? b * 4096 : h1 * 4096;
          endcase
          w[i] = qm(d, s, w[i], 1);
        end
      end
      ep++;
      if (errs == 0) begin cv = 1; break; end
      if (ep >= lim) break;
    end
  endtask

  task automatic query(input bit a, input bit b, output bit y);
    @(negedge clk);
    q_x0 = a;
    q_x1 = b;
    #1;
    y = q_y;
  endtask

  // run one training and compare with the model
  task automatic run(input int sd, input int lim, input int model_seed, input int pulse_at);
    int ep, cyc, exp_cyc;
    bit cv, y;
    int w[9];
    model(model_seed, lim, ep, cv, w);
    exp_cyc = 9 + 85 * ep;
    @(negedge clk);
    seed = 16'(sd);
    epoch_limit = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && converged == 1'b0, "R2 start clears flags", int'(done), 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == pulse_at);  // R9 stray pulse while busy
    end
    start = 1'b0;
    check(cyc == exp_cyc, "R4 R8 R9 cycles to done", cyc, exp_cyc);
    check(converged == cv, "R7 R8 converged flag", int'(converged), int'(cv));
    for (int p = 0; p < 4; p++) begin
      query(p[1], p[0], y);
      check(y == bit'(infer(w, p[1], p[0])), "R3 R5 R6 trained query", int'(y),
            infer(w, p[1], p[0]));
      if (cv) check(y == (p[1] ^ p[0]), "R10 xor after convergence", int'(y), p[1] ^ p[0]);
    end
    repeat (5) @(negedge clk);
    check(done == 1'b1 && converged == cv, "R11 flags hold", int'(converged), int'(cv));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit y;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(converged == 1'b0, "R1 converged after reset", int'(converged), 0);
    for (int p = 0; p < 4; p++) begin
      query(p[1], p[0], y);
      check(y == 1'b1, "R1 R3 query with zero weights", int'(y), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 8; v++)
      run(int'(VECS[v][31:16]), int'(VECS[v][15:0]), int'(VECS[v][31:16]), -1);
    run(0, 4, 1, -1);          // R2 seed zero acts as one
    run(16'hACE1, 0, 16'hACE1, -1);  // R8 limit zero acts as one
    run(16'h1234, 100, 16'h1234, 50);  // R9 start while busy
    run(16'h5A5A, 3, 16'h5A5A, 200);   // R9 pulse later in the run
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule